// File: doc/BRIEF.md
# Shared Bus Ownership Arbiter

This block decides which of four parties drives a shared external bus: a CPU, a transfer controller, a DMA engine, or an outside device. The three internal masters each raise a request and watch their own bit of a one-hot grant vector. The outside device uses a request/acknowledge handshake. Whoever owns the bus pulses `xfer_done` in the last cycle of its single access or burst. The arbiter only reconsiders ownership at such a boundary, or while the current owner is idle. When nothing is pending, the bus rests with the CPU.

Among the internal masters, precedence rotates through CPU, transfer controller, DMA engine and back to the CPU. A rotation pointer names the master that ranks highest at the next decision. Once the CPU has been served, it drops behind any waiting DMA-type master. If the DMA engine began waiting before the transfer controller, the DMA engine is served first, then the transfer controller, then the CPU. Two configuration inputs can demote a CPU request that targets external space. It can be placed below a DMA burst, and below transfer-controller work that is not marked locked.

A request is taken when the grant for it has been registered. A master whose grant was already showing when it raised its request may still lose that grant at the next edge.

Top module: `bus_owner_arb`

## Requirements
- R1: When `ext_req` is high at a decision point, every bit of `gnt` is 0 in the next cycle. `ext_ack` rises in the cycle after that, provided `ext_req` is still high. `ext_ack` never rises in a cycle that follows one with any grant bit set.
- R2: In the cycle after `ext_req` is sampled low while `ext_ack` is high, `ext_ack` is 0 and `gnt` shows the internal arbitration result. If no internal master is requesting, that result is the CPU.
- R3: At most one bit of `gnt` is set at any time, and `gnt` is all zero whenever `ext_ack` is 1. Encoding: bit 0 = CPU, bit 1 = transfer controller, bit 2 = DMA engine.
- R4: While a granted master is busy and `xfer_done` is low, `gnt` holds its value. This is true even if `ext_req` or requests from other masters appear.
- R5: At a decision point, requesters rank in order starting at the rotation pointer, following the cycle CPU, transfer controller, DMA engine. After a winner is served, the pointer moves to the next master in that cycle.
- R6: When the CPU finishes a transfer while the transfer controller or DMA engine is requesting, the next grant does not go to the CPU.
- R7: When the CPU has just been served and both DMA-type masters wait, the one that began waiting first is served first. If the DMA engine was first, the transfer controller follows it, and only then the CPU.
- R8: With `cfg_cpu_yield` = 1, a CPU request with `cpu_ext` = 1 loses to a DMA engine request with `dma_burst` = 1. With `cfg_cpu_yield` = 0 or `dma_burst` = 0, normal rotation applies.
- R9: With `cfg_cpu_yield` = 1, a CPU request with `cpu_ext` = 1 loses to a transfer-controller request when `cfg_tc_lock` = 0. It does not lose when `cfg_tc_lock` = 1, nor when `cpu_ext` = 0.
- R10: At a decision point with no internal request and no external request, `gnt` = 3'b001 in the next cycle.
- R11: After reset, `gnt` = 3'b001, `ext_ack` = 0, and the rotation pointer names the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU bus request |
| cpu_ext | input | 1 | CPU request targets external space |
| tc_req | input | 1 | Transfer controller request |
| dma_req | input | 1 | DMA engine request |
| dma_burst | input | 1 | DMA request is a burst |
| cfg_cpu_yield | input | 1 | Demote external CPU accesses |
| cfg_tc_lock | input | 1 | Transfer-controller work is locked (not demoting CPU) |
| xfer_done | input | 1 | Current owner finishes its transfer this cycle |
| ext_req | input | 1 | Outside device requests the bus |
| ext_ack | output | 1 | Bus handed to the outside device |
| gnt | output | 3 | One-hot internal grant (bit0 CPU, bit1 TC, bit2 DMA) |

## Verification
A corrupted rotation pointer or age bit does not show at once. It appears at the next decision point with two or more requesters, when the wrong bit of `gnt` rises one cycle after the boundary. The tests therefore drive contested boundaries from a known pointer position. A wrong phase state shows within one or two cycles. It appears either as `ext_ack` and `gnt` active together, or as an acknowledge that never comes or never drops after the handshake edge. A lost busy flag shows as a grant moving without `xfer_done`. The checks watch for each of these.

// File: rtl/arb_pkg.sv
package arb_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned NUM_MST = 3;

  typedef enum logic [1:0] {
    M_CPU = 2'd0,
    M_TC  = 2'd1,
    M_DMA = 2'd2
  } mst_e;

  typedef enum logic [1:0] {
    PH_INT = 2'd0,
    PH_REL = 2'd1,
    PH_EXT = 2'd2
  } ph_e;

  function automatic logic [NUM_MST-1:0] mst_onehot(mst_e m);
    logic [NUM_MST-1:0] r;
    r = '0;
    r[m] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int unsigned W = (STAGES < 2) ? 2 : STAGES;

  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[W-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[W-1];
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
(
  input  logic [NUM_MST-1:0] req,
  input  mst_e               ptr,
  input  logic               dma_older,
  output mst_e               win,
  output logic               win_ok
);
  timeunit 1ns;
  timeprecision 100ps;

  mst_e ord [NUM_MST];

  // ranking list starting at the pointer; age swaps the DMA-type pair
  always_comb begin
    case (ptr)
      M_TC:    if (dma_older) ord = '{M_DMA, M_TC, M_CPU};
               else           ord = '{M_TC, M_DMA, M_CPU};
      M_DMA:   ord = '{M_DMA, M_CPU, M_TC};
      default: ord = '{M_CPU, M_TC, M_DMA};
    endcase
  end

  always_comb begin
    win    = M_CPU;
    win_ok = 1'b0;
    for (int i = NUM_MST - 1; i >= 0; i--) begin
      if (req[ord[i]]) begin
        win    = ord[i];
        win_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_age.sv
module arb_age
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dma_req,
  input  logic tc_req,
  input  logic busy,
  input  mst_e owner,
  input  logic take,
  input  mst_e win,
  output logic dma_older
);
  timeunit 1ns;
  timeprecision 100ps;

  logic older_q, older_d, dma_self, tc_self, en;

  assign dma_self = busy && (owner == M_DMA);
  assign tc_self  = busy && (owner == M_TC);

  always_comb begin
    older_d = older_q;
    en      = 1'b1;
    if (take && win == M_DMA)                  older_d = 1'b0;
    else if (take && win == M_TC)              older_d = 1'b1;
    else if (dma_req && !tc_req && !dma_self)  older_d = 1'b1;
    else if (tc_req && !dma_req && !tc_self)   older_d = 1'b0;
    else                                       en      = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  older_q <= 1'b0;
    else if (en) older_q <= older_d;
  end

  assign dma_older = older_q;
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
  import arb_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_ext,
  input  logic       tc_req,
  input  logic       dma_req,
  input  logic       dma_burst,
  input  logic       cfg_cpu_yield,
  input  logic       cfg_tc_lock,
  input  logic       xfer_done,
  input  logic       ext_req,
  output logic       ext_ack,
  output logic [2:0] gnt
);
  timeunit 1ns;
  timeprecision 100ps;

  logic               rst_q_n;
  ph_e                ph_q, ph_d;
  mst_e               own_q, own_d, ptr_q, ptr_d, win;
  logic               busy_q, busy_d, pair_q, pair_d;
  logic               win_ok, dma_older, take, settle, boundary, cpu_demote, adv;
  logic [NUM_MST-1:0] req_elig;

  arb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  // configuration-dependent demotion of external CPU accesses
  assign cpu_demote = cfg_cpu_yield && cpu_ext &&
                      ((dma_req && dma_burst) || (tc_req && !cfg_tc_lock));
  assign req_elig   = {dma_req, tc_req, cpu_req && !cpu_demote};

  arb_pick u_pick (
    .req(req_elig), .ptr(ptr_q), .dma_older(dma_older),
    .win(win), .win_ok(win_ok)
  );

  arb_age u_age (
    .clk(clk), .rst_n(rst_q_n), .dma_req(dma_req), .tc_req(tc_req),
    .busy(busy_q), .owner(own_q), .take(take), .win(win),
    .dma_older(dma_older)
  );

  assign boundary = !busy_q || xfer_done;

  always_comb begin
    ph_d   = ph_q;
    settle = 1'b0;
    unique case (ph_q)
      PH_INT: if (boundary) begin
                if (ext_req) ph_d = PH_REL;
                else         settle = 1'b1;
              end
      PH_REL: if (ext_req) ph_d = PH_EXT;
              else         settle = 1'b1;
      PH_EXT: if (!ext_req) settle = 1'b1;
      default: settle = 1'b1;
    endcase
    if (settle) ph_d = PH_INT;
  end

  assign take = settle && win_ok;

  always_comb begin
    own_d  = own_q;
    busy_d = busy_q;
    ptr_d  = ptr_q;
    pair_d = pair_q;
    if (ph_d != PH_INT) begin
      busy_d = 1'b0;
    end else if (settle) begin
      if (win_ok) begin
        own_d  = win;
        busy_d = 1'b1;
        pair_d = 1'b0;
        case (win)
          M_CPU: ptr_d = M_TC;
          M_TC:  ptr_d = pair_q ? M_CPU : M_DMA;
          default: begin
            if (ptr_q == M_TC && tc_req && !pair_q) begin
              ptr_d  = M_TC;
              pair_d = 1'b1;
            end else begin
              ptr_d = M_CPU;
            end
          end
        endcase
      end else begin
        own_d  = M_CPU;
        busy_d = 1'b0;
      end
    end
  end

  assign adv = boundary || (ph_q != PH_INT);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ph_q   <= PH_INT;
      own_q  <= M_CPU;
      busy_q <= 1'b0;
      ptr_q  <= M_CPU;
      pair_q <= 1'b0;
    end else if (adv) begin
      ph_q   <= ph_d;
      own_q  <= own_d;
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      pair_q <= pair_d;
    end
  end

  assign gnt     = (ph_q == PH_INT) ? mst_onehot(own_q) : '0;
  assign ext_ack = (ph_q == PH_EXT);
endmodule

// File: rtl/arb_chk.sv
module arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_req,
  input logic       ext_ack,
  input logic       xfer_done,
  input logic [2:0] gnt,
  input logic       busy,
  input logic       cpu_req,
  input logic       tc_req,
  input logic       dma_req
);
  timeunit 1ns;
  timeprecision 100ps;

  // R3
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R3
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> (gnt == 3'b000));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done && !ext_ack && (gnt != 3'b000)) |=> $stable(gnt));

  // R1
  ext_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !ext_ack && busy && xfer_done) |=> (gnt == 3'b000));

  // R1
  ack_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ack) |-> ($past(gnt) == 3'b000));

  // R2
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ack && !ext_req) |=> !ext_ack);

  // R6
  cpu_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && gnt[0] && xfer_done && !ext_req && (tc_req || dma_req)) |=> !gnt[0]);

  // R10
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_req && !ext_ack && !cpu_req && !tc_req && !dma_req && (!busy || xfer_done))
      |=> (gnt == 3'b001));
endmodule

bind bus_owner_arb arb_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .ext_req(ext_req), .ext_ack(ext_ack),
  .xfer_done(xfer_done), .gnt(gnt), .busy(busy_q), .cpu_req(cpu_req),
  .tc_req(tc_req), .dma_req(dma_req)
);

// File: tb/sim_bus_owner_arb.sv
module sim_bus_owner_arb;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n, cpu_req, cpu_ext, tc_req, dma_req, dma_burst;
  logic       cfg_cpu_yield, cfg_tc_lock, xfer_done, ext_req, ext_ack;
  logic [2:0] gnt;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  bus_owner_arb u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ext(cpu_ext),
    .tc_req(tc_req), .dma_req(dma_req), .dma_burst(dma_burst),
    .cfg_cpu_yield(cfg_cpu_yield), .cfg_tc_lock(cfg_tc_lock),
    .xfer_done(xfer_done), .ext_req(ext_req), .ext_ack(ext_ack), .gnt(gnt)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // compares {ext_ack, gnt}
  task automatic chk(input string tag, input logic [3:0] exp);
    checks++;
    if ({ext_ack, gnt} !== exp) begin
      errors++;
      $display("FAIL %s: {ack,gnt} actual=%b expected=%b", tag, {ext_ack, gnt}, exp);
    end
  endtask

  task automatic do_reset();
    {cpu_req, cpu_ext, tc_req, dma_req, dma_burst} = '0;
    {cfg_cpu_yield, cfg_tc_lock, xfer_done, ext_req} = '0;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 reset owner", 4'b0001);
  endtask

  task automatic t_park();
    do_reset();
    repeat (3) step();
    chk("R10 idle park", 4'b0001);
    tc_req = 1'b1; step();
    chk("R5 lone TC", 4'b0010);
    tc_req = 1'b0; xfer_done = 1'b1; step();
    chk("R10 park after done", 4'b0001);
    xfer_done = 1'b0;
  endtask

  task automatic t_rotate();
    do_reset();
    cpu_req = 1'b1; tc_req = 1'b1; dma_req = 1'b1; step();
    chk("R5 pointer at CPU", 4'b0001);
    xfer_done = 1'b1; step();
    chk("R6 TC after CPU", 4'b0010);
    step();
    chk("R5 DMA after TC", 4'b0100);
    step();
    chk("R5 CPU after DMA", 4'b0001);
    xfer_done = 1'b0;
  endtask

  task automatic t_age();
    do_reset();
    cpu_req = 1'b1; step();
    dma_req = 1'b1; step();
    tc_req = 1'b1; step();
    chk("R4 CPU held", 4'b0001);
    xfer_done = 1'b1; step();
    chk("R7 older DMA first", 4'b0100);
    step();
    chk("R7 TC second", 4'b0010);
    step();
    chk("R7 CPU third", 4'b0001);
    xfer_done = 1'b0;
  endtask

  task automatic t_ext();
    do_reset();
    tc_req = 1'b1; step();
    ext_req = 1'b1; step();
    chk("R4 held against ext", 4'b0010);
    xfer_done = 1'b1; step();
    chk("R1 grants dropped", 4'b0000);
    xfer_done = 1'b0; tc_req = 1'b0; step();
    chk("R1 ack raised", 4'b1000);
    dma_req = 1'b1; step();
    chk("R3 no grant with ack", 4'b1000);
    ext_req = 1'b0; step();
    chk("R2 return to DMA", 4'b0100);
    dma_req = 1'b0; xfer_done = 1'b1; step();
    xfer_done = 1'b0;
    ext_req = 1'b1; step();
    chk("R1 idle release", 4'b0000);
    step();
    chk("R1 idle ack", 4'b1000);
    ext_req = 1'b0; step();
    chk("R2 return parked", 4'b0001);
  endtask

  task automatic t_yield_burst();
    do_reset();
    cfg_cpu_yield = 1'b1; cpu_req = 1'b1; cpu_ext = 1'b1;
    dma_req = 1'b1; dma_burst = 1'b1; step();
    chk("R8 burst beats CPU", 4'b0100);
    do_reset();
    cfg_cpu_yield = 1'b1; cpu_req = 1'b1; cpu_ext = 1'b1; dma_req = 1'b1; step();
    chk("R8 no burst", 4'b0001);
    do_reset();
    cpu_req = 1'b1; cpu_ext = 1'b1; dma_req = 1'b1; dma_burst = 1'b1; step();
    chk("R8 yield off", 4'b0001);
  endtask

  task automatic t_yield_tc();
    do_reset();
    cfg_cpu_yield = 1'b1; cpu_req = 1'b1; cpu_ext = 1'b1; tc_req = 1'b1; step();
    chk("R9 unlocked TC wins", 4'b0010);
    do_reset();
    cfg_cpu_yield = 1'b1; cfg_tc_lock = 1'b1; cpu_req = 1'b1; cpu_ext = 1'b1;
    tc_req = 1'b1; step();
    chk("R9 locked TC", 4'b0001);
    do_reset();
    cfg_cpu_yield = 1'b1; cpu_req = 1'b1; tc_req = 1'b1; step();
    chk("R9 internal CPU access", 4'b0001);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    t_reset();
    t_park();
    t_rotate();
    t_age();
    t_ext();
    t_yield_burst();
    t_yield_tc();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule